// File: doc/BRIEF.md
# DMA Address Translator

This block sits between DMA masters and physical memory. A device presents a 24-bit bus address. The block looks up one of 2048 page descriptors, one for each 8 KB page, and returns a 32-bit physical address. Along with it come a cache-inhibit flag and a fault code. Host software loads, clears and reads back descriptors through a plain indexed word port.

A device whose address space is narrower than 24 bits sits against the top of the input space: the address bits it lacks are forced to one. Each descriptor carries several fields:

- a type code
- a write-protect flag
- a whole-block flag, which demands transfer lengths that are multiples of 16 bytes
- a cache-inhibit flag
- two status bits that the block keeps up to date: used and modified

Lookups arrive on a valid/ready stream and results leave on a second valid/ready stream. A request is taken on a clock edge where both `lk_valid` and `lk_ready` are high. `lk_ready` drops in three cases:

- the result stage is full and `rs_ready` is low
- a host write collides with a lookup already in flight
- a host write targets the index being offered

A result stays on the output, unchanged, until it is taken on an edge where `rs_valid` and `rs_ready` are both high. The descriptor read takes one cycle, so a result appears two edges after its request was accepted.

Top module: `dma_xlate_unit`

## Requirements
- R1: The descriptor index is bits 23..13 of the (width-extended) address. On success the physical address is descriptor bits 31..13 followed by address bits 12..0.
- R2: When `lk_width` is w with 1 <= w <= 23, address bits 23..w are forced to one before lookup. Values 0 and 24 or above leave the address unchanged.
- R3: Descriptor type field bits 1..0 equal to 00 give fault code 1 (unused page). Values 10 and 11 give fault code 2 (malformed), and neither value is ever treated as valid.
- R4: A write lookup (`lk_write`=1) to a descriptor with bit 2 (write protect) set gives fault code 3. A read to the same page succeeds.
- R5: With descriptor bit 5 (whole-block) set, a length whose low four bits are not all zero gives fault code 3. Lengths that are multiples of 16 succeed.
- R6: `rs_cinh` equals descriptor bit 6 on a successful result, and is low on a faulting one.
- R7: Fault codes are 0 none, 1 unused page, 2 malformed, 3 access violation. On any nonzero code `rs_addr_ok` is low and `rs_paddr` is zero. On code 0 `rs_addr_ok` is high with `rs_valid`.
- R8: A successful lookup sets descriptor bit 3 (used), and a successful write lookup also sets bit 4 (modified). A faulting lookup changes no bit. Back-to-back lookups to one page keep bits set by the earlier one.
- R9: A host write in the same cycle as an offered lookup to the same index holds `lk_ready` low for that cycle. The following lookup sees the newly written descriptor, so a cleared entry faults at once.
- R10: After reset `rs_valid` is low and `lk_ready` is high. A result appears two edges after acceptance. While `rs_ready` is low, the result and all its fields hold and `lk_ready` stays low.
- R11: A host read (`hst_en`=1, `hst_we`=0) returns the descriptor word on `hst_rdata` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_en | input | 1 | Host access strobe |
| hst_we | input | 1 | Host access is a write |
| hst_idx | input | 11 | Host descriptor index |
| hst_wdata | input | 32 | Host descriptor write word |
| hst_rdata | output | 32 | Host descriptor read word, one cycle after the read |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this edge |
| lk_addr | input | 24 | Device bus address |
| lk_width | input | 5 | Device address width in bits |
| lk_write | input | 1 | Transfer is a device write to memory |
| lk_len | input | 16 | Transfer length in bytes |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_paddr | output | 32 | Translated physical address |
| rs_cinh | output | 1 | Cache inhibit for this access |
| rs_fault | output | 2 | Fault code |
| rs_addr_ok | output | 1 | Address-valid strobe toward memory |

## Verification
The bench walks a table of lookups that covers each type code, protection against reads and writes, and aligned and unaligned lengths on a whole-block page. The table also drives several device widths that must land on the top pages. A design that treated the illegal type codes as valid, or that forced the wrong address bits, would return a physical address where a fault or a different page is due. Status bits are then read back over the host port. A design that updated them on a fault, or that lost the modified bit when two lookups to one page run back to back, shows the wrong word. Directed cases hold the result under back-pressure and collide a clearing host write with a lookup to the same page. A design without the stall or the forwarding path would translate through the stale descriptor.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DESC_W = 32;
  // descriptor field positions: host software and the lookup path share this layout
  localparam int F_CINH  = 6;
  localparam int F_BLOCK = 5;
  localparam int F_MOD   = 4;
  localparam int F_USED  = 3;
  localparam int F_WPROT = 2;
  localparam int F_TYPE  = 0;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_UNUSED    = 2'd1,
    FLT_MALFORMED = 2'd2,
    FLT_ACCESS    = 2'd3
  } fault_e;
endpackage

// File: rtl/xlat_width_fold.sv
module xlat_width_fold #(
  parameter int AW = 24,
  parameter int WW = 5
) (
  input  logic [AW-1:0] addr_in,
  input  logic [WW-1:0] width,
  output logic [AW-1:0] addr_out
);
  logic narrow;
  assign narrow = (width != '0) && (width < WW'(AW));

  for (genvar b = 0; b < AW; b++) begin : g_bit
    // bits at or above the device width are not driven by the device: tie high
    assign addr_out[b] = addr_in[b] | (narrow && (width <= WW'(b)));
  end
endmodule

// File: rtl/xlat_desc_store.sv
module xlat_desc_store #(
  parameter int IDX_W = 11,
  parameter int DW    = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             la_en,
  input  logic [IDX_W-1:0] la_idx,
  output logic [DW-1:0]    la_data,
  input  logic             hb_en,
  input  logic [IDX_W-1:0] hb_idx,
  output logic [DW-1:0]    hb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (la_en) la_data <= mem[la_idx];
    if (hb_en) hb_data <= mem[hb_idx];
  end
endmodule

// File: rtl/xlat_judge.sv
module xlat_judge
  import xlat_pkg::*;
#(
  parameter int PAGE_SHIFT = 13
) (
  input  logic [DESC_W-1:0]     desc,
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic                  is_write,
  input  logic                  len_ragged,
  output fault_e                fault,
  output logic [DESC_W-1:0]     paddr,
  output logic                  cinh,
  output logic [DESC_W-1:0]     wb_word
);
  logic [1:0] typ;
  assign typ = desc[F_TYPE +: 2];

  always_comb begin
    if (typ[1])
      fault = FLT_MALFORMED;
    else if (!typ[0])
      fault = FLT_UNUSED;
    else if ((desc[F_WPROT] && is_write) || (desc[F_BLOCK] && len_ragged))
      fault = FLT_ACCESS;
    else
      fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? {desc[DESC_W-1:PAGE_SHIFT], offset} : '0;
  assign cinh  = (fault == FLT_NONE) && desc[F_CINH];

  always_comb begin
    wb_word = desc;
    wb_word[F_USED] = 1'b1;
    if (is_write) wb_word[F_MOD] = 1'b1;
  end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import xlat_pkg::*;
#(
  parameter int IN_AW      = 24,
  parameter int PAGE_SHIFT = 13,
  parameter int LEN_W      = 16,
  parameter int BLK_BYTES  = 16,
  localparam int IDX_W = IN_AW - PAGE_SHIFT,
  localparam int WID_W = $clog2(IN_AW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_en,
  input  logic              hst_we,
  input  logic [IDX_W-1:0]  hst_idx,
  input  logic [DESC_W-1:0] hst_wdata,
  output logic [DESC_W-1:0] hst_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IN_AW-1:0]  lk_addr,
  input  logic [WID_W-1:0]  lk_width,
  input  logic              lk_write,
  input  logic [LEN_W-1:0]  lk_len,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [DESC_W-1:0] rs_paddr,
  output logic              rs_cinh,
  output logic [1:0]        rs_fault,
  output logic              rs_addr_ok
);
  localparam logic [LEN_W-1:0] BLK_MASK = LEN_W'(BLK_BYTES - 1);

  // stage A: address folding and index
  logic [IN_AW-1:0] a_ext;
  logic [IDX_W-1:0] a_idx;

  xlat_width_fold #(.AW(IN_AW), .WW(WID_W)) u_fold (
    .addr_in(lk_addr), .width(lk_width), .addr_out(a_ext)
  );
  assign a_idx = a_ext[IN_AW-1:PAGE_SHIFT];

  logic host_wr, host_rd;
  assign host_wr = hst_en && hst_we;
  assign host_rd = hst_en && !hst_we;

  // stage B registers
  logic                  s1_vld;
  logic [IDX_W-1:0]      s1_idx;
  logic [PAGE_SHIFT-1:0] s1_off;
  logic                  s1_wr;
  logic                  s1_ragged;
  logic                  fwd_v;
  logic [DESC_W-1:0]     fwd_d;

  // output registers
  logic              out_vld;
  logic [DESC_W-1:0] out_paddr;
  logic              out_cinh;
  fault_e            out_fault;

  logic adv, accept;
  assign adv      = (!out_vld || rs_ready) && !(host_wr && s1_vld);
  assign lk_ready = adv && !(host_wr && (hst_idx == a_idx));
  assign accept   = lk_valid && lk_ready;

  // descriptor storage
  logic [DESC_W-1:0] ram_q;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic [DESC_W-1:0] mem_wdat;

  xlat_desc_store #(.IDX_W(IDX_W), .DW(DESC_W)) u_store (
    .clk(clk),
    .wr_en(mem_we), .wr_idx(mem_widx), .wr_data(mem_wdat),
    .la_en(accept), .la_idx(a_idx), .la_data(ram_q),
    .hb_en(host_rd), .hb_idx(hst_idx), .hb_data(hst_rdata)
  );

  // stage B evaluation
  logic [DESC_W-1:0] desc_b;
  fault_e            j_fault;
  logic [DESC_W-1:0] j_paddr;
  logic              j_cinh;
  logic [DESC_W-1:0] j_wb;

  assign desc_b = fwd_v ? fwd_d : ram_q;

  xlat_judge #(.PAGE_SHIFT(PAGE_SHIFT)) u_judge (
    .desc(desc_b), .offset(s1_off), .is_write(s1_wr), .len_ragged(s1_ragged),
    .fault(j_fault), .paddr(j_paddr), .cinh(j_cinh), .wb_word(j_wb)
  );

  logic wb_en;
  assign wb_en    = adv && s1_vld && (j_fault == FLT_NONE);
  assign mem_we   = host_wr || wb_en;
  assign mem_widx = host_wr ? hst_idx : s1_idx;
  assign mem_wdat = host_wr ? hst_wdata : j_wb;

  // index that stage B will hold after this edge
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_live;
  assign nxt_idx  = accept ? a_idx : s1_idx;
  assign nxt_live = accept || (s1_vld && !adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_idx    <= '0;
      s1_off    <= '0;
      s1_wr     <= 1'b0;
      s1_ragged <= 1'b0;
      fwd_v     <= 1'b0;
      fwd_d     <= '0;
    end else begin
      if (adv) begin
        s1_vld <= accept;
        if (accept) begin
          s1_idx    <= a_idx;
          s1_off    <= a_ext[PAGE_SHIFT-1:0];
          s1_wr     <= lk_write;
          s1_ragged <= |(lk_len & BLK_MASK);
        end
      end
      // a write landing on the entry stage B reads next is bypassed around the RAM
      if (nxt_live && mem_we && (mem_widx == nxt_idx)) begin
        fwd_v <= 1'b1;
        fwd_d <= mem_wdat;
      end else if (accept) begin
        fwd_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_paddr <= '0;
      out_cinh  <= 1'b0;
      out_fault <= FLT_NONE;
    end else if (adv) begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_paddr <= j_paddr;
        out_cinh  <= j_cinh;
        out_fault <= j_fault;
      end
    end
  end

  assign rs_valid   = out_vld;
  assign rs_paddr   = out_paddr;
  assign rs_cinh    = out_cinh;
  assign rs_fault   = out_fault;
  assign rs_addr_ok = out_vld && (out_fault == FLT_NONE);
endmodule

// File: rtl/xlat_unit_props.sv
module xlat_unit_props #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_en,
  input logic             hst_we,
  input logic [IDX_W-1:0] hst_idx,
  input logic [IDX_W-1:0] a_idx,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             s1_vld,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic [31:0]      rs_paddr,
  input logic             rs_cinh,
  input logic [1:0]       rs_fault,
  input logic             rs_addr_ok
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_paddr) && $stable(rs_fault) && $stable(rs_cinh));

  p_from_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rs_valid) |-> $past(s1_vld));

  p_host_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hst_en && hst_we && lk_valid && (hst_idx == a_idx) |-> !lk_ready);

  p_inh_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_cinh |-> (rs_fault == 2'd0) && rs_addr_ok);

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && (rs_fault != 2'd0) |-> (rs_paddr == 32'd0) && !rs_addr_ok);
endmodule

bind dma_xlate_unit xlat_unit_props #(.IDX_W(IDX_W)) u_props (
  .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we), .hst_idx(hst_idx),
  .a_idx(a_idx), .lk_valid(lk_valid), .lk_ready(lk_ready), .s1_vld(s1_vld),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr), .rs_cinh(rs_cinh),
  .rs_fault(rs_fault), .rs_addr_ok(rs_addr_ok)
);

// File: tb/dma_xlate_unit_test.sv
module dma_xlate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_en = 1'b0, hst_we = 1'b0;
  logic [10:0] hst_idx = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        lk_valid = 1'b0, lk_ready;
  logic [23:0] lk_addr = '0;
  logic [4:0]  lk_width = '0;
  logic        lk_write = 1'b0;
  logic [15:0] lk_len = '0;
  logic        rs_valid, rs_ready = 1'b1;
  logic [31:0] rs_paddr;
  logic        rs_cinh;
  logic [1:0]  rs_fault;
  logic        rs_addr_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dma_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we), .hst_idx(hst_idx),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .lk_width(lk_width), .lk_write(lk_write), .lk_len(lk_len),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr), .rs_cinh(rs_cinh),
    .rs_fault(rs_fault), .rs_addr_ok(rs_addr_ok)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [23:0] a;
    logic [4:0]  w;
    logic        wr;
    logic [15:0] len;
    logic [31:0] pa;
    logic [1:0]  f;
    logic        ci;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  24'h00A123, 5'd24, 1'b0, 16'd4,  32'h2468A123, 2'd0, 1'b0},
    '{4'd3,  24'h00C000, 5'd24, 1'b0, 16'd4,  32'h00000000, 2'd1, 1'b0},
    '{4'd3,  24'h00E010, 5'd24, 1'b0, 16'd4,  32'h00000000, 2'd2, 1'b0},
    '{4'd3,  24'h010000, 5'd24, 1'b0, 16'd4,  32'h00000000, 2'd2, 1'b0},
    '{4'd4,  24'h012004, 5'd24, 1'b0, 16'd4,  32'hABCDE004, 2'd0, 1'b0},
    '{4'd4,  24'h012004, 5'd24, 1'b1, 16'd4,  32'h00000000, 2'd3, 1'b0},
    '{4'd5,  24'h014000, 5'd24, 1'b0, 16'd32, 32'h00010000, 2'd0, 1'b0},
    '{4'd5,  24'h014000, 5'd24, 1'b0, 16'd20, 32'h00000000, 2'd3, 1'b0},
    '{4'd5,  24'h014000, 5'd24, 1'b1, 16'd48, 32'h00010000, 2'd0, 1'b0},
    '{4'd6,  24'h016ABC, 5'd24, 1'b0, 16'd4,  32'h40002ABC, 2'd0, 1'b1},
    '{4'd2,  24'h000010, 5'd16, 1'b0, 16'd4,  32'h55554010, 2'd0, 1'b0},
    '{4'd2,  24'h00FFFE, 5'd16, 1'b0, 16'd4,  32'h80001FFE, 2'd0, 1'b0},
    '{4'd1,  24'hFFFFFE, 5'd24, 1'b0, 16'd4,  32'h80001FFE, 2'd0, 1'b0},
    '{4'd2,  24'h00A000, 5'd0,  1'b0, 16'd4,  32'h2468A000, 2'd0, 1'b0},
    '{4'd2,  24'h000005, 5'd13, 1'b0, 16'd4,  32'h80000005, 2'd0, 1'b0}
  };

  function automatic string rq_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [10:0] i, input logic [31:0] d);
    @(negedge clk);
    hst_en = 1'b1; hst_we = 1'b1; hst_idx = i; hst_wdata = d;
    @(negedge clk);
    hst_en = 1'b0; hst_we = 1'b0;
  endtask

  task automatic hread(input logic [10:0] i, output logic [31:0] d);
    @(negedge clk);
    hst_en = 1'b1; hst_we = 1'b0; hst_idx = i;
    @(negedge clk);
    hst_en = 1'b0;
    d = hst_rdata;
  endtask

  task automatic lookup(input logic [23:0] a, input logic [4:0] w, input logic wr,
                        input logic [15:0] len, output logic [31:0] pa,
                        output logic [1:0] f, output logic ci, output logic ok);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_width = w; lk_write = wr; lk_len = len;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    while (!rs_valid) @(negedge clk);
    pa = rs_paddr; f = rs_fault; ci = rs_cinh; ok = rs_addr_ok;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pa, rd, held;
    logic [1:0]  f;
    logic        ci, ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset rs_valid", {63'd0, rs_valid}, 64'd0);
    chk("R10 reset lk_ready", {63'd0, lk_ready}, 64'd1);

    // descriptor setup
    hwrite(11'h005, 32'h2468A001);
    hwrite(11'h006, 32'h11110000);
    hwrite(11'h007, 32'h00004002);
    hwrite(11'h008, 32'h00006003);
    hwrite(11'h009, 32'hABCDE005);
    hwrite(11'h00A, 32'h00010021);
    hwrite(11'h00B, 32'h40002041);
    hwrite(11'h7F8, 32'h55554001);
    hwrite(11'h7FF, 32'h80000001);
    hwrite(11'h00C, 32'h22222001);
    hwrite(11'h00D, 32'h33332001);

    // R11: host readback of an untouched word
    hread(11'h00C, rd);
    chk("R11 host read", {32'd0, rd}, {32'd0, 32'h22222001});

    // table walk: R1..R7
    for (int k = 0; k < NV; k++) begin
      lookup(VECS[k].a, VECS[k].w, VECS[k].wr, VECS[k].len, pa, f, ci, ok);
      chk(rq_name(VECS[k].rq), {28'd0, pa, f, ci, ok},
          {28'd0, VECS[k].pa, VECS[k].f, VECS[k].ci, (VECS[k].f == 2'd0)});
    end

    // R8: status bits seen through host reads
    hread(11'h005, rd); chk("R8 used on read", {32'd0, rd}, {32'd0, 32'h2468A009});
    hread(11'h009, rd); chk("R8 fault leaves bits", {32'd0, rd}, {32'd0, 32'hABCDE00D});
    hread(11'h00A, rd); chk("R8 modified on write", {32'd0, rd}, {32'd0, 32'h00010039});
    hread(11'h006, rd); chk("R8 unused page untouched", {32'd0, rd}, {32'd0, 32'h11110000});
    hread(11'h007, rd); chk("R8 malformed untouched", {32'd0, rd}, {32'd0, 32'h00004002});

    // R10: back-pressure hold
    @(negedge clk); rs_ready = 1'b0;
    lookup(24'h016000, 5'd24, 1'b0, 16'd4, pa, f, ci, ok);
    held = pa;
    repeat (4) @(negedge clk);
    chk("R10 held valid", {63'd0, rs_valid}, 64'd1);
    chk("R10 held paddr", {32'd0, rs_paddr}, {32'd0, held});
    chk("R10 ready low while full", {63'd0, lk_ready}, 64'd0);
    chk("R10 held cinh", {63'd0, rs_cinh}, 64'd1);
    rs_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {63'd0, rs_valid}, 64'd0);

    // R9: clearing write collides with a lookup to the same page
    @(negedge clk);
    hst_en = 1'b1; hst_we = 1'b1; hst_idx = 11'h00C; hst_wdata = 32'h0;
    lk_valid = 1'b1; lk_addr = 24'h018000; lk_width = 5'd24; lk_write = 1'b0; lk_len = 16'd4;
    #1;
    chk("R9 stall on same index", {63'd0, lk_ready}, 64'd0);
    @(negedge clk);
    hst_en = 1'b0; hst_we = 1'b0;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    while (!rs_valid) @(negedge clk);
    chk("R9 cleared entry faults", {61'd0, rs_fault, rs_addr_ok}, {61'd0, 2'd1, 1'b0});

    // R8: back-to-back write then read on one page keeps modified bit
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 24'h01A000; lk_width = 5'd24; lk_write = 1'b1; lk_len = 16'd4;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_write = 1'b0;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    repeat (4) @(negedge clk);
    hread(11'h00D, rd);
    chk("R8 back-to-back keeps modified", {32'd0, rd}, {32'd0, 32'h33332019});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule